// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers a bank of level-sensitive interrupt sources, registers their levels every cycle, and combines the masked levels into one interrupt line that feeds a fixed input of an upstream primary controller. Software sets and clears mask bits through write-one registers on a simple memory-mapped word port and can read back both the raw levels and the masked status.

A second enable register lets software route chosen sources around the combining logic. When a source's passthrough bit is set, the output line of the same index follows that source's registered level; lines whose passthrough bit is clear stay low. The register window is 4 KiB, addressed by a 12-bit byte address; reads return data one cycle after the request.

Top module: `sic_passthru_ctrl`

## Requirements
- R1: Each source input is captured into a raw level register one clock after it is sampled, and the raw level reads back at byte offset 0x04.
- R2: The combined output `irq_o` is high one clock after the registered raw level ANDed with the mask register is nonzero, and low one clock after it is zero.
- R3: For each index i, `pass_o[i]` equals the registered raw level of source i one clock later when passthrough bit i is set, and is held low when it is clear.
- R4: A read at offset 0x00 returns raw level ANDed with mask, and a read at offset 0x08 returns the passthrough-enable register; unused upper bits read zero.
- R5: Writing offset 0x08 sets every mask bit whose write-data bit is 1, writing offset 0x0C clears every mask bit whose write-data bit is 1; bits written as 0 keep their value.
- R6: Writing offset 0x20 sets, and writing offset 0x24 clears, the passthrough-enable bits whose write-data bit is 1; the passthrough outputs reflect the new enable one clock after the write.
- R7: Reads at any offset other than 0x00, 0x04 and 0x08 return zero, and writes to any offset other than 0x08, 0x0C, 0x20 and 0x24 change no register.
- R8: Synchronous active-high reset clears the raw level, mask and passthrough-enable registers, `irq_o`, `pass_o` and `rdata`.
- R9: Read data appears on `rdata` the clock after `rd_en` is sampled high and is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address within the 4 KiB window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one clock after the read |
| irq_o | output | 1 | Combined masked interrupt to the primary controller |
| pass_o | output | N_SRC | Per-source passthrough lines to the primary controller |

## Verification
The bench builds the block with its defaults: 32 sources, a 32-bit data word and a 12-bit address. With as many sources as data bits, every mask, level and passthrough bit lands on the bus, so random patterns reach the top and bottom bit lanes, all-ones and all-zero words, and writes that set or clear bits across the full word. Unmapped offsets near the mapped ones and at the top of the 4 KiB window are exercised directly.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int OFS_W = 12;
  // read offsets
  localparam logic [OFS_W-1:0] RD_STATUS  = 12'h000;
  localparam logic [OFS_W-1:0] RD_RAW     = 12'h004;
  localparam logic [OFS_W-1:0] RD_PASS_EN = 12'h008;
  // write offsets
  localparam logic [OFS_W-1:0] WR_MASK_SET = 12'h008;
  localparam logic [OFS_W-1:0] WR_MASK_CLR = 12'h00C;
  localparam logic [OFS_W-1:0] WR_PASS_SET = 12'h020;
  localparam logic [OFS_W-1:0] WR_PASS_CLR = 12'h024;
endpackage

// File: rtl/sic_level_capture.sv
module sic_level_capture #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] level_o
);
  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= src_i;
  end
endmodule

// File: rtl/sic_setclr_reg.sv
module sic_setclr_reg #(
  parameter int N_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [N_BITS-1:0] bits_i,
  output logic [N_BITS-1:0] q_o
);
  logic [N_BITS-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (set_en) nxt = nxt | bits_i;
    if (clr_en) nxt = nxt & ~bits_i;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt;
  end
endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  level_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic [N_SRC-1:0]  pen_i,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(RD_STATUS))       sel = DATA_W'(level_i & mask_i);
    else if (addr == ADDR_W'(RD_RAW))     sel = DATA_W'(level_i);
    else if (addr == ADDR_W'(RD_PASS_EN)) sel = DATA_W'(pen_i);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
    else            rdata <= '0;
  end
endmodule

// File: rtl/sic_out_stage.sv
module sic_out_stage #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] level_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] pen_i,
  output logic             irq_o,
  output logic [N_SRC-1:0] pass_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(level_i & mask_i);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pass_o[i] <= 1'b0;
      else     pass_o[i] <= pen_i[i] & level_i[i];
    end
  end
endmodule

// File: rtl/sic_passthru_ctrl.sv
module sic_passthru_ctrl
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic [N_SRC-1:0]  pass_o
);
  logic [N_SRC-1:0] level_q, mask_q, pen_q;
  logic [N_SRC-1:0] wbits;
  logic mask_set, mask_clr, pen_set, pen_clr;

  assign wbits    = wdata[N_SRC-1:0];
  assign mask_set = wr_en && (addr == ADDR_W'(WR_MASK_SET));
  assign mask_clr = wr_en && (addr == ADDR_W'(WR_MASK_CLR));
  assign pen_set  = wr_en && (addr == ADDR_W'(WR_PASS_SET));
  assign pen_clr  = wr_en && (addr == ADDR_W'(WR_PASS_CLR));

  sic_level_capture #(.N_SRC(N_SRC)) u_level (
    .clk(clk), .rst(rst), .src_i(src_i), .level_o(level_q)
  );

  sic_setclr_reg #(.N_BITS(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .set_en(mask_set), .clr_en(mask_clr),
    .bits_i(wbits), .q_o(mask_q)
  );

  sic_setclr_reg #(.N_BITS(N_SRC)) u_pen (
    .clk(clk), .rst(rst), .set_en(pen_set), .clr_en(pen_clr),
    .bits_i(wbits), .q_o(pen_q)
  );

  sic_read_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .level_i(level_q), .mask_i(mask_q), .pen_i(pen_q), .rdata(rdata)
  );

  sic_out_stage #(.N_SRC(N_SRC)) u_out (
    .clk(clk), .rst(rst), .level_i(level_q), .mask_i(mask_q),
    .pen_i(pen_q), .irq_o(irq_o), .pass_o(pass_o)
  );
endmodule

// File: rtl/sic_passthru_ctrl_chk.sv
module sic_passthru_ctrl_chk #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pass_o,
  input logic [N_SRC-1:0]  level_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  pen_q
);
  logic rd_mapped;
  assign rd_mapped = (addr == ADDR_W'(12'h000)) || (addr == ADDR_W'(12'h004)) ||
                     (addr == ADDR_W'(12'h008));

  a_r1_level_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> level_q == $past(src_i));

  a_r2_combined: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == $past(|(level_q & mask_q)));

  a_r3_pass_gated: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pass_o & ~$past(pen_q)) == '0);

  a_r5_mask_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12'h008)) |=>
      ((mask_q & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));

  a_r5_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12'h00C)) |=> ((mask_q & $past(wdata[N_SRC-1:0])) == '0));

  a_r6_pen_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12'h020)) |=>
      ((pen_q & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));

  a_r7_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_mapped) |=> rdata == '0);

  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);
endmodule

bind sic_passthru_ctrl sic_passthru_ctrl_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .pass_o(pass_o),
  .level_q(level_q), .mask_q(mask_q), .pen_q(pen_q)
);

// File: tb/sic_passthru_ctrl_tb.sv
module sic_passthru_ctrl_tb;
  localparam int N = 32;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_i = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_o;
  logic [N-1:0] pass_o;

  int checks = 0, errors = 0;
  logic [N-1:0] m_mask = '0, m_pen = '0, m_src = '0;
  bit done = 0;

  always #5 clk = ~clk;

  sic_passthru_ctrl #(.N_SRC(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .pass_o(pass_o)
  );

  function automatic logic exp_irq(input logic [N-1:0] s, input logic [N-1:0] m);
    return |(s & m);
  endfunction

  function automatic logic [N-1:0] exp_pass(input logic [N-1:0] s, input logic [N-1:0] p);
    return s & p;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  // two edges: level register, then output registers
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " R2 irq"}, DW'(irq_o), DW'(exp_irq(m_src, m_mask)));
    check({tag, " R3 pass"}, DW'(pass_o), DW'(exp_pass(m_src, m_pen)));
  endtask

  task automatic check_regs(input string tag);
    logic [DW-1:0] d;
    rd(12'h004, d); check({tag, " R1 raw"}, d, DW'(m_src));
    rd(12'h000, d); check({tag, " R4 status"}, d, DW'(m_src & m_mask));
    rd(12'h008, d); check({tag, " R4 pen"}, d, DW'(m_pen));
  endtask

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // reset state while inputs are active
    src_i = '1;
    @(negedge clk);
    check("R8 irq in reset", DW'(irq_o), '0);
    check("R8 pass in reset", DW'(pass_o), '0);
    check("R8 rdata in reset", rdata, '0);
    src_i = '0;
    rst = 1'b0;
    settle();
    check_regs("R8 after reset");
    check_outputs("R8 after reset");

    // R9: idle rdata and read latency
    check("R9 idle rdata", rdata, '0);

    // directed: edge lanes
    m_src = 32'h8000_0001; src_i = m_src;
    settle();
    check_outputs("R2 no mask");
    wr(12'h008, 32'h8000_0000); m_mask = 32'h8000_0000;
    settle();
    check_outputs("R5 set top bit");
    wr(12'h020, 32'h0000_0001); m_pen = 32'h0000_0001;
    @(negedge clk);
    check("R6 pass one clock after write", DW'(pass_o), 32'h0000_0001);
    check_regs("R6 directed");
    wr(12'h00C, 32'h8000_0000); m_mask = '0;
    settle();
    check_outputs("R5 clear top bit");
    wr(12'h024, 32'h0000_0001); m_pen = '0;
    settle();
    check_outputs("R6 clear pen");

    // R7: unmapped writes change nothing, unmapped reads zero
    wr(12'h008, 32'h00FF_00FF); m_mask = 32'h00FF_00FF;
    wr(12'h020, 32'h0F0F_0F0F); m_pen = 32'h0F0F_0F0F;
    m_src = 32'hFFFF_FFFF; src_i = m_src;
    wr(12'h000, '1); wr(12'h004, '1); wr(12'h010, '1);
    wr(12'h028, '1); wr(12'hFFC, '1); wr(12'h009, '1);
    settle();
    check_regs("R7 after unmapped writes");
    check_outputs("R7 after unmapped writes");
    rd(12'h00C, d); check("R7 read 0x0C", d, '0);
    rd(12'h020, d); check("R7 read 0x20", d, '0);
    rd(12'hFFC, d); check("R7 read 0xFFC", d, '0);
    rd(12'h001, d); check("R7 read 0x01", d, '0);

    // all-ones and all-zero words
    wr(12'h008, '1); m_mask = '1;
    wr(12'h020, '1); m_pen = '1;
    m_src = '0; src_i = m_src;
    settle();
    check_outputs("R2 zero level full mask");
    m_src = 32'h0000_0400; src_i = m_src;
    settle();
    check_outputs("R3 single source");
    wr(12'h00C, '1); m_mask = '0;
    wr(12'h024, '1); m_pen = '0;
    settle();
    check_outputs("R5 R6 clear all");

    // constrained random
    for (int it = 0; it < 60; it++) begin
      int op;
      logic [N-1:0] v;
      op = int'($urandom_range(0, 5));
      v = N'($urandom());
      case (op)
        0: begin wr(12'h008, DW'(v)); m_mask = m_mask | v; end
        1: begin wr(12'h00C, DW'(v)); m_mask = m_mask & ~v; end
        2: begin wr(12'h020, DW'(v)); m_pen = m_pen | v; end
        3: begin wr(12'h024, DW'(v)); m_pen = m_pen & ~v; end
        4: begin wr(AW'(12'h100 + ($urandom_range(0, 200) << 2)), DW'(v)); end
        default: begin m_src = v; src_i = v; end
      endcase
      settle();
      check_outputs("rand");
      if ((it % 4) == 0) check_regs("rand");
    end

    // mid-run reset with live sources
    m_src = '1; src_i = m_src;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset irq", DW'(irq_o), '0);
    check("R8 mid reset pass", DW'(pass_o), '0);
    rst = 1'b0; m_mask = '0; m_pen = '0;
    settle();
    check_regs("R8 mid reset");
    check_outputs("R8 mid reset");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule